// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the register file of one channel of a descriptor-driven DMA engine. Software reaches it with 32-bit word accesses inside a 256-byte window. A write to the control word does not store a value. It performs a masked update: the upper half of the written word says which status bits to change, and the lower half gives their new values. The block keeps a status image (run, pause, flush, wake, dead, active, branch-taken), the command pointer and three condition-select words. It drives all of them to the channel sequencer, which lies outside this block.

The sequencer reports its own events through single-cycle hardware strobes. These kill the channel, halt it, set or clear branch-taken, and clear wake. The block drives three strobes back. A kick tells the sequencer to resume after a write leaves the channel active. A fetch follows an accepted command-pointer write. A flush-busy level asks the attached device to drain and stays high until the device answers with a done strobe.

A two-state machine runs the flush handshake. State `FL_IDLE` moves to `FL_BUSY` on any flush request (transition "start"). `FL_BUSY` returns to `FL_IDLE` when the done strobe arrives and no new request comes in the same cycle (transition "finish"). In every other case it stays in `FL_BUSY` (transition "hold").

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register is zero: the status word, the command pointer and all three select words read 0, and kick_o, fetch_o and flush_busy_o are low.
- R2: A write to word offset 0 changes only the status bits whose mask bit (bit 16+n for status bit n) is 1. Run is bit 15 and pause is bit 14, and pause takes the written value whenever its mask bit is set.
- R3: A control write with run masked and written 0 clears both run and dead (bit 11) in the next cycle.
- R4: Wake (bit 12) is set by a control write only if run is 1 once that write has been applied. Otherwise wake stays as it was.
- R5: After a control write, active (bit 10) is 0 if pause is 1 or run is 0. Otherwise it is set when the write masked run or pause or wrote wake as 1, and is left unchanged when it did none of these. Active is never 1 while run is 0 or pause is 1.
- R6: A control write requests a flush when it writes flush (bit 13) as 1 under mask, or when it leaves pause set or run clear. From the next cycle, flush_busy_o and status bit 13 are 1, and they stay 1 until a cycle in which flush_done is high and no new request arrives.
- R7: A write to word offset 3 is ignored while active is 1. Otherwise the command pointer takes the written word with its low 4 bits cleared, and fetch_o pulses for one cycle.
- R8: A read of offset 0 or offset 1 returns the status word. Offsets 3, 4, 5 and 6 return the pointer and the select words. Every other offset in the window reads 0.
- R9: kick_o pulses for one cycle after a control write whose final result leaves active at 1, and it is low otherwise.
- R10: Hardware strobes are applied on top of a control write in the same cycle. Kill sets dead and clears active, halt clears active, and there are branch-taken set and clear strobes for bit 8 (set wins) and a wake-clear strobe.
- R11: Writes to offsets 4, 5 and 6 store the whole word, which then appears on the interrupt, branch and wait select outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Word offset within the channel window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| hw_kill | input | 1 | Sequencer: set dead, clear active |
| hw_halt | input | 1 | Sequencer: clear active |
| hw_bt_set | input | 1 | Sequencer: set branch-taken |
| hw_bt_clr | input | 1 | Sequencer: clear branch-taken |
| hw_wake_clr | input | 1 | Sequencer: clear wake at command fetch |
| flush_done | input | 1 | Device reports that the flush is complete |
| status_o | output | 32 | Status word |
| cmd_ptr_o | output | 32 | Command pointer |
| intr_sel_o | output | 32 | Interrupt condition select word |
| branch_sel_o | output | 32 | Branch condition select word |
| wait_sel_o | output | 32 | Wait condition select word |
| flush_busy_o | output | 1 | Flush requested and not yet done |
| kick_o | output | 1 | Resume pulse to the sequencer |
| fetch_o | output | 1 | Descriptor fetch pulse after a pointer write |

## Verification
The bench builds the block with its default parameters: a 32-bit data word, a 256-byte window of 64 word offsets, and 16-byte pointer alignment. These values put the highest offset, 63, and the four cleared pointer bits within reach of the bench's checks. A table of control words walks the status image through run, wake, pause, unpause, an all-unmasked write, an explicit flush and a stop. Directed cases then cover a held flush, the pointer lock while active, and hardware strobes that coincide with a software write.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    // status bit positions (decoded by the sequencer)
    localparam int B_RUN    = 15;
    localparam int B_PAUSE  = 14;
    localparam int B_FLUSH  = 13;
    localparam int B_WAKE   = 12;
    localparam int B_DEAD   = 11;
    localparam int B_ACTIVE = 10;
    localparam int B_BT     = 8;

    // word offsets inside the channel window
    localparam int OFF_CTRL    = 0;
    localparam int OFF_STAT    = 1;
    localparam int OFF_CPTR    = 3;
    localparam int OFF_SEL0    = 4;
    localparam int NUM_SEL     = 3;

    typedef struct packed {
        logic run;
        logic pause;
        logic wake;
        logic dead;
        logic active;
        logic bt;
    } chan_stat_t;

    typedef enum logic {
        FL_IDLE,
        FL_BUSY
    } flush_state_t;
endpackage

// File: rtl/dma_chan_status_calc.sv
module dma_chan_status_calc
    import dma_chan_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  chan_stat_t          cur,
    input  logic                ctl_wr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                hw_kill,
    input  logic                hw_halt,
    input  logic                hw_bt_set,
    input  logic                hw_bt_clr,
    input  logic                hw_wake_clr,
    output chan_stat_t          nxt,
    output logic                flush_req,
    output logic                kick
);
    localparam int HALF = DATA_W / 2;

    logic [HALF-1:0] msk;
    logic [HALF-1:0] val;
    chan_stat_t      s;
    logic            fl;

    assign msk = wdata[DATA_W-1:HALF];
    assign val = wdata[HALF-1:0];

    always_comb begin
        s  = cur;
        fl = 1'b0;
        if (ctl_wr) begin
            if (msk[B_RUN]) begin
                if (val[B_RUN]) begin
                    s.run = 1'b1;
                end else begin
                    s.run  = 1'b0;
                    s.dead = 1'b0;
                end
            end
            if (msk[B_WAKE] && val[B_WAKE] && s.run) s.wake = 1'b1;
            if (msk[B_PAUSE]) s.pause = val[B_PAUSE];
            if (msk[B_FLUSH] && val[B_FLUSH]) fl = 1'b1;
            if (s.pause || !s.run) begin
                s.active = 1'b0;
                fl       = 1'b1;
            end else if (msk[B_RUN] || msk[B_PAUSE]) begin
                s.active = 1'b1;
            end else if (msk[B_WAKE] && val[B_WAKE]) begin
                s.active = 1'b1;
            end
        end
        // sequencer strobes land on top of the software update
        if (hw_wake_clr) s.wake = 1'b0;
        if (hw_bt_clr)   s.bt   = 1'b0;
        if (hw_bt_set)   s.bt   = 1'b1;
        if (hw_halt)     s.active = 1'b0;
        if (hw_kill) begin
            s.dead   = 1'b1;
            s.active = 1'b0;
        end
        nxt       = s;
        flush_req = fl;
        kick      = ctl_wr && s.active;
    end
endmodule

// File: rtl/dma_chan_flush_fsm.sv
module dma_chan_flush_fsm
    import dma_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush_req,
    input  logic flush_done,
    output logic busy
);
    flush_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE: if (flush_req) state_d = FL_BUSY;                   // start
            FL_BUSY: if (flush_done && !flush_req) state_d = FL_IDLE;    // finish
            default: state_d = FL_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == FL_BUSY);
    end

    // R6: a request is visible as busy in the next cycle
    assert_flush_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> busy);
    // R6: done without a new request ends the flush
    assert_flush_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && flush_done && !flush_req) |=> !busy);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int WINDOW_BYTES = 256,
    parameter int PTR_ALIGN    = 16
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      bus_wr,
    input  logic [$clog2(WINDOW_BYTES/(DATA_W/8))-1:0] bus_addr,
    input  logic [DATA_W-1:0]                         bus_wdata,
    output logic [DATA_W-1:0]                         bus_rdata,
    input  logic                                      hw_kill,
    input  logic                                      hw_halt,
    input  logic                                      hw_bt_set,
    input  logic                                      hw_bt_clr,
    input  logic                                      hw_wake_clr,
    input  logic                                      flush_done,
    output logic [DATA_W-1:0]                         status_o,
    output logic [DATA_W-1:0]                         cmd_ptr_o,
    output logic [DATA_W-1:0]                         intr_sel_o,
    output logic [DATA_W-1:0]                         branch_sel_o,
    output logic [DATA_W-1:0]                         wait_sel_o,
    output logic                                      flush_busy_o,
    output logic                                      kick_o,
    output logic                                      fetch_o
);
    localparam int AW       = $clog2(WINDOW_BYTES / (DATA_W / 8));
    localparam int LOW_BITS = $clog2(PTR_ALIGN);
    localparam int HALF     = DATA_W / 2;

    chan_stat_t        stat_q, stat_d;
    logic              flush_req, kick_d;
    logic [DATA_W-1:0] cptr_q;
    logic [DATA_W-1:0] sel_q [NUM_SEL];
    logic              fetch_q, kick_q;
    logic              ctl_wr, cptr_wr;

    assign ctl_wr  = bus_wr && (bus_addr == AW'(OFF_CTRL));
    assign cptr_wr = bus_wr && (bus_addr == AW'(OFF_CPTR)) && !stat_q.active;

    dma_chan_status_calc #(.DATA_W(DATA_W)) i_calc (
        .cur        (stat_q),
        .ctl_wr     (ctl_wr),
        .wdata      (bus_wdata),
        .hw_kill    (hw_kill),
        .hw_halt    (hw_halt),
        .hw_bt_set  (hw_bt_set),
        .hw_bt_clr  (hw_bt_clr),
        .hw_wake_clr(hw_wake_clr),
        .nxt        (stat_d),
        .flush_req  (flush_req),
        .kick       (kick_d)
    );

    dma_chan_flush_fsm i_flush (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_req (flush_req),
        .flush_done(flush_done),
        .busy      (flush_busy_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q  <= '0;
            cptr_q  <= '0;
            fetch_q <= 1'b0;
            kick_q  <= 1'b0;
        end else begin
            stat_q  <= stat_d;
            kick_q  <= kick_d;
            fetch_q <= cptr_wr;
            if (cptr_wr) cptr_q <= {bus_wdata[DATA_W-1:LOW_BITS], LOW_BITS'(0)};
        end
    end

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        always_ff @(posedge clk) begin
            if (!rst_n) sel_q[g] <= '0;
            else if (bus_wr && bus_addr == AW'(OFF_SEL0 + g)) sel_q[g] <= bus_wdata;
        end
    end

    always_comb begin
        status_o           = '0;
        status_o[B_RUN]    = stat_q.run;
        status_o[B_PAUSE]  = stat_q.pause;
        status_o[B_FLUSH]  = flush_busy_o;
        status_o[B_WAKE]   = stat_q.wake;
        status_o[B_DEAD]   = stat_q.dead;
        status_o[B_ACTIVE] = stat_q.active;
        status_o[B_BT]     = stat_q.bt;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFF_CTRL) || bus_addr == AW'(OFF_STAT)) bus_rdata = status_o;
        if (bus_addr == AW'(OFF_CPTR)) bus_rdata = cptr_q;
        for (int i = 0; i < NUM_SEL; i++) begin
            if (bus_addr == AW'(OFF_SEL0 + i)) bus_rdata = sel_q[i];
        end
    end

    assign cmd_ptr_o    = cptr_q;
    assign intr_sel_o   = sel_q[0];
    assign branch_sel_o = sel_q[1];
    assign wait_sel_o   = sel_q[2];
    assign kick_o       = kick_q;
    assign fetch_o      = fetch_q;

    // R5: active only with run set and pause clear
    assert_active_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[B_ACTIVE] |-> (status_o[B_RUN] && !status_o[B_PAUSE]));
    // R7: pointer locked while active
    assert_cptr_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFF_CPTR) && status_o[B_ACTIVE])
            |=> ($stable(cmd_ptr_o) && !fetch_o));
    // R9: a kick is only seen with the channel active
    assert_kick_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        kick_o |-> status_o[B_ACTIVE]);
    // R3: stopping clears run and dead
    assert_run_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && bus_wdata[HALF + B_RUN] && !bus_wdata[B_RUN] && !hw_kill)
            |=> (!status_o[B_RUN] && !status_o[B_DEAD]));
endmodule

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    // {control word, expected status[15:0], expected kick}
    localparam logic [48:0] VEC [NV] = '{
        {32'h0000_0000, 16'h2000, 1'b0},   // idle write -> flush only
        {32'h8000_8000, 16'h8400, 1'b1},   // run
        {32'h1000_1000, 16'h9400, 1'b1},   // wake with run
        {32'h4000_4000, 16'hF000, 1'b0},   // pause -> inactive + flush
        {32'h4000_0000, 16'h9400, 1'b1},   // unpause
        {32'h0000_FFFF, 16'h9400, 1'b1},   // nothing masked
        {32'h2000_2000, 16'hB400, 1'b1},   // explicit flush
        {32'h8000_0000, 16'h3000, 1'b0}    // stop
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hw_kill = 1'b0, hw_halt = 1'b0, hw_bt_set = 1'b0, hw_bt_clr = 1'b0, hw_wake_clr = 1'b0;
    logic        flush_done = 1'b1;
    logic [31:0] status_o, cmd_ptr_o, intr_sel_o, branch_sel_o, wait_sel_o;
    logic        flush_busy_o, kick_o, fetch_o;

    int checks = 0;
    int failures = 0;
    bit ended = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_regs i_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_kill(hw_kill),
        .hw_halt(hw_halt), .hw_bt_set(hw_bt_set), .hw_bt_clr(hw_bt_clr),
        .hw_wake_clr(hw_wake_clr), .flush_done(flush_done), .status_o(status_o),
        .cmd_ptr_o(cmd_ptr_o), .intr_sel_o(intr_sel_o), .branch_sel_o(branch_sel_o),
        .wait_sel_o(wait_sel_o), .flush_busy_o(flush_busy_o), .kick_o(kick_o),
        .fetch_o(fetch_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // one cycle of stimulus, outputs sampled after the edge
    task automatic cyc(input logic wr, input logic [5:0] a, input logic [31:0] d,
                       input logic kill, input logic halt, input logic bset,
                       input logic bclr, input logic wclr);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        hw_kill = kill; hw_halt = halt; hw_bt_set = bset; hw_bt_clr = bclr; hw_wake_clr = wclr;
        @(negedge clk);
        bus_wr = 1'b0; hw_kill = 1'b0; hw_halt = 1'b0;
        hw_bt_set = 1'b0; hw_bt_clr = 1'b0; hw_wake_clr = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 status", status_o, 32'h0);
        chk("R1 cmdptr", cmd_ptr_o, 32'h0);
        chk("R1 sel", intr_sel_o | branch_sel_o | wait_sel_o, 32'h0);
        chk("R1 pulses", {29'd0, kick_o, fetch_o, flush_busy_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R5 R6 R9 table walk
        for (int i = 0; i < NV; i++) begin
            wr(6'd0, VEC[i][48:17]);
            chk($sformatf("R2/R5/R6 vec%0d status", i), status_o, {16'h0, VEC[i][16:1]});
            chk($sformatf("R9 vec%0d kick", i), {31'd0, kick_o}, {31'd0, VEC[i][0]});
            chk($sformatf("R6 vec%0d busy", i), {31'd0, flush_busy_o}, {31'd0, VEC[i][14]});
        end

        // R10 wake clear strobe (flush from stop also ends)
        cyc(1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R10 wake clear", status_o, 32'h0000_0000);
        // R4 wake while stopped is not taken
        wr(6'd0, 32'h1000_1000);
        chk("R4 wake needs run", status_o, 32'h0000_2000);

        // R7 pointer write while inactive
        wr(6'd3, 32'h1234_567F);
        chk("R7 ptr aligned", cmd_ptr_o, 32'h1234_5670);
        chk("R7 fetch pulse", {31'd0, fetch_o}, 32'd1);
        @(negedge clk);
        chk("R7 fetch one cycle", {31'd0, fetch_o}, 32'd0);
        wr(6'd0, 32'h8000_8000);
        wr(6'd3, 32'hAAAA_AAA0);
        chk("R7 ptr locked", cmd_ptr_o, 32'h1234_5670);
        chk("R7 no fetch when locked", {31'd0, fetch_o}, 32'd0);

        // R8 R11 read map and selects
        wr(6'd4, 32'h000F_0005);
        wr(6'd5, 32'h0003_0001);
        wr(6'd6, 32'h000A_000C);
        chk("R11 intr sel", intr_sel_o, 32'h000F_0005);
        chk("R11 branch sel", branch_sel_o, 32'h0003_0001);
        chk("R11 wait sel", wait_sel_o, 32'h000A_000C);
        rd("R8 ctrl reads status", 6'd0, 32'h0000_8400);
        rd("R8 status", 6'd1, 32'h0000_8400);
        rd("R8 unused hi", 6'd2, 32'h0);
        rd("R8 ptr", 6'd3, 32'h1234_5670);
        rd("R8 sel read", 6'd5, 32'h0003_0001);
        rd("R8 mode reads zero", 6'd7, 32'h0);
        rd("R8 top offset", 6'd63, 32'h0);

        // R10 kill, then R3 stop clears dead
        cyc(1'b0, 6'd0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10 kill", status_o, 32'h0000_8800);
        wr(6'd0, 32'h8000_0000);
        chk("R3 stop clears dead", status_o, 32'h0000_2000);

        // R10 halt on top of a same-cycle run write
        cyc(1'b1, 6'd0, 32'h8000_8000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10 halt over write", status_o, 32'h0000_8000);
        chk("R9 no kick when halted", {31'd0, kick_o}, 32'd0);
        cyc(1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R10 bt set", status_o, 32'h0000_8100);
        cyc(1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R10 bt clear", status_o, 32'h0000_8000);

        // R6 flush held until done
        flush_done = 1'b0;
        wr(6'd0, 32'h2000_2000);
        chk("R6 flush set", status_o, 32'h0000_A000);
        repeat (3) @(negedge clk);
        chk("R6 flush held", {31'd0, flush_busy_o}, 32'd1);
        flush_done = 1'b1;
        @(negedge clk);
        chk("R6 flush released", status_o, 32'h0000_8000);

        // R1 reset again clears everything
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 re-reset status", status_o, 32'h0);
        chk("R1 re-reset ptr/sel", cmd_ptr_o | intr_sel_o | wait_sel_o, 32'h0);

        finish_run();
    end
endmodule